// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a serial successive-approximation ADC that is read in fixed ten-clock frames. It runs entirely on one fast clock. From that clock it produces a free-running conversion clock for the converter and a gated shift clock for the frame. A request carries a 4-bit channel number. The controller then drops the active-low select line and waits a qualification interval counted in conversion-clock periods. It issues ten shift-clock pulses, sending the channel number out and taking the previous conversion result in. Finally it raises the select line and holds off for the conversion interval.

The converter returns, in every frame, the result of the conversion started by the frame before. The controller therefore keeps the channel number of the previous frame. It reports that number next to each 10-bit result and flags the first frame after reset as carrying no real conversion. A busy output covers the whole frame plus the conversion hold-off, and requests that arrive while busy is high are dropped.

Top module: `serial_adc_host`

## Requirements
- R1: While reset is held and in the first cycles after it, `adc_cs_n`=1, `adc_ioclk`=0, `adc_addr`=0, `busy`=0 and `res_valid`=0.
- R2: `adc_sysclk` runs freely from reset, with high and low phases of exactly SYS_HALF fast-clock cycles each.
- R3: From the cycle `adc_cs_n` falls to the first rise of `adc_ioclk`, at least SETUP_SYS full `adc_sysclk` periods (SETUP_SYS*2*SYS_HALF fast cycles) elapse.
- R4: Each frame has exactly DATA_W (10) `adc_ioclk` pulses. Every high phase and every low phase between pulses lasts IO_HALF fast cycles, with IO_HALF >= SYS_HALF.
- R5: The channel number is sent MSB first on `adc_addr`. Bit k (k=1..4, counting from the MSB) is stable from before rise k until after fall k. During pulses 5 to 10, `adc_addr` is 0.
- R6: `adc_dout` is sampled on each `adc_ioclk` rise. The value taken at rise k becomes result bit 10-k, so `res_data[9]` is the bit presented right after select went low.
- R7: After the tenth `adc_ioclk` fall, `adc_cs_n` stays high for at least CONV_SYS full `adc_sysclk` periods before it may fall again.
- R8: `res_valid` is a one-cycle pulse in the cycle `adc_cs_n` returns high. `res_chan` is the channel sent in the preceding frame, and `res_stale`=1 only for the first frame after reset (with `res_chan`=0).
- R9: `busy` goes high in the cycle after `start` is taken and stays high until the conversion hold-off ends. A `start` seen while `busy` is high is ignored: no extra frame runs, and the ignored channel never appears on `res_chan`.
- R10: While `adc_cs_n` is high, `adc_ioclk` and `adc_addr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, sole clock of the block |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a frame (taken only when not busy) |
| chan | input | 4 | Channel number to send in the requested frame |
| adc_dout | input | 1 | Serial result bit from the converter |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sysclk | output | 1 | Free-running conversion clock to the converter |
| adc_ioclk | output | 1 | Frame shift clock to the converter |
| adc_addr | output | 1 | Serial channel number to the converter |
| busy | output | 1 | Frame or conversion hold-off in progress |
| res_valid | output | 1 | One-cycle pulse: result fields are new |
| res_data | output | 10 | Result read in the finished frame |
| res_chan | output | 4 | Channel the result belongs to |
| res_stale | output | 1 | Result is the power-up value, not a conversion |

## Verification
Two events can land on the same fast-clock edge: the end of the conversion hold-off and a waiting request. When they do, the next frame opens in the very next cycle. The bench provokes this by holding `start` high across the whole frame with a new channel, so the controller relaunches the instant busy drops. It then judges the result from the select-high time it measured before the relaunch, which must still be at least the full hold-off. It also judges the pipelined channel tag of the relaunched frame. Requests pulsed in the middle of the shift phase and during the hold-off check the ignore rule against the frame count and the channel tags that the converter model sees.

// File: rtl/serial_adc_host.sv
module serial_adc_host #(
  parameter int SYS_HALF  = 2,
  parameter int IO_HALF   = 4,
  parameter int SETUP_SYS = 3,
  parameter int CONV_SYS  = 44,
  parameter int DATA_W    = 10,
  parameter int CH_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   chan,
  input  logic              adc_dout,
  output logic              adc_cs_n,
  output logic              adc_sysclk,
  output logic              adc_ioclk,
  output logic              adc_addr,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              res_stale
);
  localparam int SC_W = $clog2(SYS_HALF + 1);
  localparam int IO_W = $clog2(IO_HALF + 1);
  localparam int WT_MAX = (SETUP_SYS > CONV_SYS) ? SETUP_SYS : CONV_SYS;
  localparam int WT_W = $clog2(WT_MAX + 1);
  localparam int PC_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_CONV} state_t;

  state_t            state;
  logic [SC_W-1:0]   sys_cnt;
  logic [IO_W-1:0]   io_cnt;
  logic [WT_W-1:0]   wait_cnt;
  logic [PC_W-1:0]   pulse;
  logic [CH_W-1:0]   addr_sh, cur_chan, prev_chan;
  logic [DATA_W-1:0] data_sh;
  logic              first;

  wire sys_tick = (sys_cnt == SC_W'(SYS_HALF - 1));
  wire sys_rise = sys_tick & ~adc_sysclk;
  wire io_tick  = (io_cnt == IO_W'(IO_HALF - 1));

  assign busy     = (state != S_IDLE);
  assign adc_addr = ~adc_cs_n & addr_sh[CH_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_cnt    <= '0;
      adc_sysclk <= 1'b0;
    end else begin
      sys_cnt <= sys_tick ? '0 : sys_cnt + SC_W'(1);
      if (sys_tick) adc_sysclk <= ~adc_sysclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      adc_cs_n  <= 1'b1;
      adc_ioclk <= 1'b0;
      io_cnt    <= '0;
      wait_cnt  <= '0;
      pulse     <= '0;
      addr_sh   <= '0;
      cur_chan  <= '0;
      prev_chan <= '0;
      data_sh   <= '0;
      first     <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      res_stale <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_SETUP;
          adc_cs_n <= 1'b0;
          addr_sh  <= chan;
          cur_chan <= chan;
          wait_cnt <= '0;
        end
        S_SETUP: if (sys_rise) begin
          if (wait_cnt == WT_W'(SETUP_SYS)) begin
            state  <= S_SHIFT;
            io_cnt <= '0;
            pulse  <= '0;
          end else begin
            wait_cnt <= wait_cnt + WT_W'(1);
          end
        end
        S_SHIFT: begin
          io_cnt <= io_tick ? '0 : io_cnt + IO_W'(1);
          if (io_tick) begin
            if (!adc_ioclk) begin
              adc_ioclk <= 1'b1;
              data_sh   <= {data_sh[DATA_W-2:0], adc_dout};
            end else begin
              adc_ioclk <= 1'b0;
              pulse     <= pulse + PC_W'(1);
              addr_sh   <= addr_sh << 1;
              if (pulse == PC_W'(DATA_W - 1)) begin
                state     <= S_CONV;
                adc_cs_n  <= 1'b1;
                wait_cnt  <= '0;
                res_valid <= 1'b1;
                res_data  <= data_sh;
                res_chan  <= prev_chan;
                res_stale <= first;
                first     <= 1'b0;
                prev_chan <= cur_chan;
              end
            end
          end
        end
        default: if (sys_rise) begin
          if (wait_cnt == WT_W'(CONV_SYS)) state <= S_IDLE;
          else wait_cnt <= wait_cnt + WT_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_adc_host_chk.sv
module serial_adc_host_chk #(
  parameter int SYS_HALF  = 2,
  parameter int IO_HALF   = 4,
  parameter int SETUP_SYS = 3,
  parameter int CONV_SYS  = 44
) (
  input logic clk,
  input logic rst_n,
  input logic adc_cs_n,
  input logic adc_sysclk,
  input logic adc_ioclk,
  input logic adc_addr,
  input logic busy,
  input logic res_valid
);
  int su_cnt, hi_cnt, io_hi, sys_hi;
  logic su_done, had_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_cnt <= 0; su_done <= 1'b0; hi_cnt <= 0; had_frame <= 1'b0;
      io_hi <= 0; sys_hi <= 0;
    end else begin
      if (adc_cs_n) begin
        su_cnt <= 0; su_done <= 1'b0;
        if (hi_cnt < 100000) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt <= 0;
        if (!su_done) begin
          if (adc_ioclk) su_done <= 1'b1;
          else if (su_cnt < 100000) su_cnt <= su_cnt + 1;
        end
      end
      if (res_valid) had_frame <= 1'b1;
      io_hi  <= adc_ioclk  ? io_hi + 1  : 0;
      sys_hi <= adc_sysclk ? sys_hi + 1 : 0;
    end
  end

  assert_sysclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sysclk) |-> sys_hi == SYS_HALF);
  assert_setup_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && !su_done && adc_ioclk) |-> su_cnt >= SETUP_SYS * 2 * SYS_HALF);
  assert_io_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_ioclk) |-> io_hi == IO_HALF);
  assert_conv_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (had_frame && $fell(adc_cs_n)) |-> hi_cnt >= CONV_SYS * 2 * SYS_HALF);
  assert_valid_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_cs_n));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_busy_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);
  assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> (!adc_ioclk && !adc_addr));
endmodule

bind serial_adc_host serial_adc_host_chk #(
  .SYS_HALF(SYS_HALF), .IO_HALF(IO_HALF), .SETUP_SYS(SETUP_SYS), .CONV_SYS(CONV_SYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_sysclk(adc_sysclk),
  .adc_ioclk(adc_ioclk), .adc_addr(adc_addr), .busy(busy), .res_valid(res_valid)
);

// File: tb/tb_serial_adc_host.sv
module tb_serial_adc_host;
  localparam int SYS_HALF = 2, IO_HALF = 4, SETUP_SYS = 3, CONV_SYS = 44;
  localparam int SETUP_MIN = SETUP_SYS * 2 * SYS_HALF;
  localparam int CONV_MIN  = CONV_SYS * 2 * SYS_HALF;

  logic clk = 0, rst_n = 0, start = 0, sdo = 0;
  logic [3:0] chan = 0;
  logic cs_n, sysclk, ioclk, addr, busy, valid, stale;
  logic [9:0] rdata;
  logic [3:0] rchan;

  serial_adc_host #(.SYS_HALF(SYS_HALF), .IO_HALF(IO_HALF), .SETUP_SYS(SETUP_SYS),
                    .CONV_SYS(CONV_SYS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .adc_dout(sdo),
    .adc_cs_n(cs_n), .adc_sysclk(sysclk), .adc_ioclk(ioclk), .adc_addr(addr),
    .busy(busy), .res_valid(valid), .res_data(rdata), .res_chan(rchan), .res_stale(stale));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;

  function automatic logic [9:0] conv(input logic [3:0] a, input int n);
    return 10'((int'(a) * 61 + n * 23 + 5) & 10'h3FF);
  endfunction

  // converter model
  logic [9:0] dev_last = 10'h2A5, dsh = 0;
  logic [3:0] daddr = 0;
  int dcnt = 0, dev_n = 0;
  bit addr_extra = 0;
  always @(negedge cs_n) begin
    dsh = dev_last; dcnt = 0; daddr = 0; addr_extra = 0; sdo = dsh[9];
  end
  always @(posedge ioclk) begin
    if (dcnt < 4) daddr = {daddr[2:0], addr};
    else if (addr) addr_extra = 1;
  end
  always @(negedge ioclk) begin
    dcnt++;
    dsh = {dsh[8:0], 1'b0}; sdo = dsh[9];
    if (dcnt == 10) begin dev_last = conv(daddr, dev_n); dev_n++; end
  end

  // monitors, sampled away from the active edge
  logic p_cs = 1, p_io = 0, p_sys = 0;
  int pulses = 0, su_cnt = 0, su_meas = 0, hi_cnt = 0, gap_meas = 0;
  int io_run = 0, sys_run = 0, phase_err = 0, sys_err = 0, sys_edges = 0, idle_err = 0;
  bit seen_rise = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        pulses = 0; su_cnt = 0; seen_rise = 0; gap_meas = hi_cnt;
      end
      if (cs_n) begin
        hi_cnt++;
        if (ioclk || addr) idle_err++;
      end else hi_cnt = 0;
      if (!cs_n && !p_io && ioclk) begin
        pulses++;
        if (!seen_rise) begin seen_rise = 1; su_meas = su_cnt; end
        else if (io_run != IO_HALF) phase_err++;
      end
      if (p_io && !ioclk && io_run != IO_HALF) phase_err++;
      if (!cs_n && !seen_rise && !ioclk) su_cnt++;
      io_run = (ioclk == p_io) ? io_run + 1 : 1;
      if (sysclk != p_sys) begin
        if (sys_edges > 0 && sys_run != SYS_HALF) sys_err++;
        sys_edges++; sys_run = 1;
      end else sys_run++;
      p_cs = cs_n; p_io = ioclk; p_sys = sysclk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    finish_run();
  end

  logic [9:0] exp_val = 10'h2A5;
  logic [3:0] exp_chan = 0;
  bit exp_stale = 1;
  int nconv = 0;

  task automatic launch(input logic [3:0] ch, input bit hold);
    @(negedge clk); start = 1; chan = ch;
    @(negedge clk); if (!hold) start = 0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
  endtask

  task automatic finish_frame(input logic [3:0] ch, input bit poke);
    int t = 0;
    while (!valid && t < 3000) begin
      @(negedge clk); t++;
      if (poke && t == 40) begin start = 1; chan = ~ch; @(negedge clk); start = 0; t++; end
    end
    chk(valid == 1'b1, "R8 valid seen", valid, 1);
    chk(rdata == exp_val, "R6 result data", rdata, exp_val);
    chk(rchan == exp_chan, "R8 result channel", rchan, exp_chan);
    chk(stale == exp_stale, "R8 stale flag", stale, exp_stale);
    chk(pulses == 10, "R4 pulse count", pulses, 10);
    chk(phase_err == 0, "R4 phase length", phase_err, 0);
    chk(su_meas >= SETUP_MIN, "R3 select setup", su_meas, SETUP_MIN);
    chk(daddr == ch, "R5 address bits", daddr, ch);
    chk(addr_extra == 0, "R5 address idle in pulses 5-10", addr_extra, 0);
    if (nconv > 0) chk(gap_meas >= CONV_MIN, "R7 conversion gap", gap_meas, CONV_MIN);
    @(negedge clk);
    chk(valid == 1'b0, "R8 valid one cycle", valid, 0);
    exp_val = conv(ch, nconv); nconv++; exp_chan = ch; exp_stale = 0;
    t = 0;
    while (busy && t < 3000) begin
      @(negedge clk); t++;
      if (poke && t == 30) begin start = 1; chan = ~ch; @(negedge clk); start = 0; t++; end
    end
    chk(cs_n == 1'b1 && busy == 1'b0, "R9 busy ends with select high", busy, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b0 && cs_n == 1'b1, "R9 ignored start left no frame", busy, 0);
      chk(dev_n == nconv, "R9 frame count", dev_n, nconv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && ioclk == 0 && addr == 0 && busy == 0 && valid == 0, "R1 in reset",
        {cs_n, ioclk, addr, busy, valid}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1 && ioclk == 0 && busy == 0 && valid == 0, "R1 after reset",
        {cs_n, ioclk, busy, valid}, 4'b1000);
    for (int c = 0; c < 16; c++) begin
      launch(4'(c), 0);
      finish_frame(4'(c), (c == 5 || c == 11));
    end
    for (int k = 0; k < 3; k++) begin
      logic [3:0] c1, c2;
      c1 = 4'(3 + k * 5); c2 = 4'(14 - k * 3);
      launch(c1, 1);
      @(negedge clk); chan = c2;
      finish_frame(c1, 0);
      @(negedge clk);
      chk(busy == 1'b1 && cs_n == 1'b0, "R9 held start relaunches next cycle", busy, 1);
      start = 0;
      finish_frame(c2, 0);
    end
    chk(sys_err == 0 && sys_edges > 100, "R2 system clock phases", sys_err, 0);
    chk(idle_err == 0, "R10 idle lines", idle_err, 0);
    finish_run();
  end
endmodule